// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight level-sensitive interrupt request lines and presents them to a processor through a byte-wide register interface with one address bit. The address bit picks between a command port (address bit low) and a data port (address bit high). Software programs the controller with a short sequence of setup words, and then works it with single-byte commands. The controller keeps three 8-bit registers: pending requests, requests in service, and a mask. It raises an interrupt output whenever an unmasked request outranks everything already in service. When the processor acknowledges, the controller places a vector byte on the data bus in that same cycle.

Priority is fixed, and input 0 ranks highest. A setup sequence starts with a command-port write that has bit 4 set. The data-port writes that follow are captured in this order:

1. the vector base;
2. an optional cascade word, which is only stored and appears on an output for the surrounding system;
3. an optional mode word, which can enable automatic end-of-interrupt.

Once the sequence is finished, data-port writes load the mask. Command-port writes then select which register a command-port read returns, or they retire one in-service bit at a time.

All control pins are plain level signals sampled on the rising clock edge, and none of them carries a handshake. A strobe held for one cycle is one access. Read data and the acknowledge vector are combinational from the registered state, so they are valid in the cycle the strobe is high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service register is 0x00, command-port reads return the request register, and int_out is low.
- R2: A command-port write with bit 4 set starts a setup sequence. That write sets the mask to 0xFF, clears the in-service register, selects the request register for command-port reads, and turns automatic end-of-interrupt off. The first data-port word after it is the vector base. Data-port words consumed by the sequence do not change the mask.
- R3: Outside a setup sequence, a data-port write loads the mask and a data-port read returns it. A mask bit of 1 keeps that input from raising int_out.
- R4: int_out is high exactly when some unmasked pending input n has no in-service bit at any index from 0 to n. Input 0 ranks highest.
- R5: While inta is high and int_out is high, dout carries vector base + n, where n is the lowest-numbered eligible input. At that clock edge, in-service bit n is set and request bit n is cleared.
- R6: While inta is high and int_out is low, dout carries vector base + 7 and the in-service register does not change. This holds even when input 7 is masked.
- R7: A command-port write of 0x60+n (n from 0 to 7) clears in-service bit n and leaves the other in-service bits unchanged.
- R8: A command-port write of 0x0A selects the request register for later command-port reads, and 0x0B selects the in-service register. The selection stays until another selection command is written.
- R9: When bit 1 of the mode word was 1 in the latest setup sequence, an acknowledge leaves the in-service register unchanged. Without a mode word, acknowledges set in-service bits.
- R10: Each request bit takes the value of its input one clock later, except in the acknowledge cycle that clears it.
- R11: Bit 1 of the first setup word set to 1 means no cascade word follows. Bit 0 set to 1 means a mode word follows. The cascade word is stored unchanged on casc_cfg, and the sequence ends after the last word it expects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, qualifies rd and wr |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| a0 | input | 1 | Port select: 0 command port, 1 data port |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, or the vector while inta is high; 0 otherwise |
| irq_in | input | 8 | Level-sensitive request lines |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| casc_cfg | output | 8 | Stored cascade word from the last setup sequence |

## Verification
A corrupted in-service bit is visible at the ports in two ways. It changes int_out in the same cycle, because a stale bit hides lower-priority requests and a lost bit lets them nest. It also returns on the next command-port read once the in-service register is selected. A sequencer stuck in the wrong step steers the next data-port word to the wrong place, so the mask readback or the following acknowledge vector is wrong one access later. A bad vector base or a wrong winner index is exposed directly on dout during the acknowledge cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_e;

  // command-port opcode fields
  localparam int          BIT_START   = 4;
  localparam int          BIT_SELCMD  = 3;
  localparam logic [2:0]  EOI_PREFIX  = 3'b011;
  localparam logic [1:0]  SEL_REQ     = 2'b10;
  localparam logic [1:0]  SEL_SVC     = 2'b11;
endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_cmd,
  input  logic               wr_data,
  input  logic [BUS_W-1:0]   wdata,
  output logic [NUM_IRQ-1:0] imr,
  output logic [BUS_W-1:0]   vec_base,
  output logic [BUS_W-1:0]   casc_cfg,
  output logic               aeoi,
  output logic               sel_svc,
  output logic               init_clr,
  output logic               eoi_req,
  output logic [IDX_W-1:0]   eoi_idx,
  output logic               seq_busy
);
  seq_state_e st_q;
  logic       want_mode_q;
  logic       no_casc_q;
  logic       cmd_start;
  logic       cmd_select;

  assign cmd_start  = wr_cmd & wdata[BIT_START];
  assign cmd_select = wr_cmd & ~wdata[BIT_START] & wdata[BIT_SELCMD];
  assign eoi_req    = wr_cmd & ~wdata[BIT_START] & ~wdata[BIT_SELCMD] &
                      (wdata[7:5] == EOI_PREFIX);
  assign eoi_idx    = wdata[IDX_W-1:0];
  assign init_clr   = cmd_start;
  assign seq_busy   = (st_q != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SEQ_IDLE;
      want_mode_q <= 1'b0;
      no_casc_q   <= 1'b0;
      imr         <= '1;
      vec_base    <= '0;
      casc_cfg    <= '0;
      aeoi        <= 1'b0;
      sel_svc     <= 1'b0;
    end else if (cmd_start) begin
      st_q        <= SEQ_BASE;
      want_mode_q <= wdata[0];
      no_casc_q   <= wdata[1];
      imr         <= '1;
      aeoi        <= 1'b0;
      sel_svc     <= 1'b0;
    end else if (cmd_select) begin
      if (wdata[1:0] == SEL_REQ) sel_svc <= 1'b0;
      else if (wdata[1:0] == SEL_SVC) sel_svc <= 1'b1;
    end else if (wr_data) begin
      unique case (st_q)
        SEQ_IDLE: imr <= wdata[NUM_IRQ-1:0];
        SEQ_BASE: begin
          vec_base <= wdata;
          if (!no_casc_q)      st_q <= SEQ_CASC;
          else if (want_mode_q) st_q <= SEQ_MODE;
          else                 st_q <= SEQ_IDLE;
        end
        SEQ_CASC: begin
          casc_cfg <= wdata;
          st_q     <= want_mode_q ? SEQ_MODE : SEQ_IDLE;
        end
        SEQ_MODE: begin
          aeoi <= wdata[1];
          st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] irr,
  input  logic [NUM_IRQ-1:0] imr,
  input  logic [NUM_IRQ-1:0] isr,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx
);
  logic [NUM_IRQ-1:0] pend;
  logic [NUM_IRQ-1:0] blocked;
  logic [NUM_IRQ-1:0] eligible;

  assign pend = irr & ~imr;

  // an input is blocked by any in-service bit of equal or higher rank
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_rank
    if (n == 0) begin : g_first
      assign blocked[n] = isr[0];
    end else begin : g_rest
      assign blocked[n] = isr[n] | blocked[n-1];
    end
    assign eligible[n] = pend[n] & ~blocked[n];
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (eligible[k]) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/prio_irq_track.sv
module prio_irq_track #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               take,
  input  logic [IDX_W-1:0]   take_idx,
  input  logic               aeoi,
  input  logic               eoi_req,
  input  logic [IDX_W-1:0]   eoi_idx,
  input  logic               init_clr,
  output logic [NUM_IRQ-1:0] irr,
  output logic [NUM_IRQ-1:0] isr
);
  logic [NUM_IRQ-1:0] grant;
  logic [NUM_IRQ-1:0] retire;

  assign grant  = take    ? (NUM_IRQ'(1) << take_idx) : '0;
  assign retire = eoi_req ? (NUM_IRQ'(1) << eoi_idx)  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
    end else begin
      irr <= irq_in & ~grant;
      if (init_clr) isr <= '0;
      else          isr <= (isr & ~retire) | (aeoi ? '0 : grant);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               rd,
  input  logic               wr,
  input  logic               a0,
  input  logic [BUS_W-1:0]   din,
  output logic [BUS_W-1:0]   dout,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               int_out,
  input  logic               inta,
  output logic [BUS_W-1:0]   casc_cfg
);
  localparam int IDX_W = $clog2(NUM_IRQ);

  logic               wr_cmd, wr_data, rd_any;
  logic [NUM_IRQ-1:0] imr_q, irr_q, isr_q;
  logic [BUS_W-1:0]   vec_base;
  logic               aeoi, sel_svc, init_clr, eoi_req, seq_busy;
  logic [IDX_W-1:0]   eoi_idx, win_idx;
  logic               win_valid;
  logic [BUS_W-1:0]   vector, rd_val;

  assign wr_cmd  = cs & wr & ~a0;
  assign wr_data = cs & wr &  a0;
  assign rd_any  = cs & rd;

  prio_irq_cfg #(.NUM_IRQ(NUM_IRQ)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_data(wr_data), .wdata(din),
    .imr(imr_q), .vec_base(vec_base), .casc_cfg(casc_cfg), .aeoi(aeoi),
    .sel_svc(sel_svc), .init_clr(init_clr), .eoi_req(eoi_req),
    .eoi_idx(eoi_idx), .seq_busy(seq_busy)
  );

  prio_irq_resolve #(.NUM_IRQ(NUM_IRQ)) u_res (
    .irr(irr_q), .imr(imr_q), .isr(isr_q),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  prio_irq_track #(.NUM_IRQ(NUM_IRQ)) u_trk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .take(inta & win_valid), .take_idx(win_idx), .aeoi(aeoi),
    .eoi_req(eoi_req), .eoi_idx(eoi_idx), .init_clr(init_clr),
    .irr(irr_q), .isr(isr_q)
  );

  assign int_out = win_valid;
  assign vector  = vec_base + (win_valid ? BUS_W'(win_idx) : BUS_W'(NUM_IRQ - 1));

  always_comb begin
    if (a0)           rd_val = BUS_W'(imr_q);
    else if (sel_svc) rd_val = BUS_W'(isr_q);
    else              rd_val = BUS_W'(irr_q);
  end

  assign dout = inta ? vector : (rd_any ? rd_val : '0);
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       wr,
  input logic       a0,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       inta,
  input logic       int_out,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic [7:0] vec_base,
  input logic       seq_busy
);
  AST_START_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !a0 && din[4]) |=> (imr == 8'hFF && isr == 8'h00)); // R2

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && a0 && !seq_busy) |=> (imr == $past(din))); // R3

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !a0 && din[7:3] == 5'b01100 && !inta) |=> !isr[$past(din[2:0])]); // R7

  AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !(cs && wr)) |=> ($countones(isr & ~$past(isr)) <= 1)); // R5

  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out) |-> (dout == vec_base + 8'd7)); // R6

  AST_SPURIOUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !(cs && wr)) |=> (isr == $past(isr))); // R6
endmodule

bind prio_irq_ctrl prio_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .a0(a0), .din(din),
  .dout(dout), .inta(inta), .int_out(int_out), .imr(imr_q), .isr(isr_q),
  .vec_base(vec_base), .seq_busy(seq_busy)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, a0 = 1'b0, inta = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] irq_in = 8'h00;
  logic [7:0] dout, casc_cfg;
  logic       int_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .a0(a0),
    .din(din), .dout(dout), .irq_in(irq_in), .int_out(int_out),
    .inta(inta), .casc_cfg(casc_cfg)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte for every read or acknowledge cycle
  always @(negedge clk) begin
    if (rst_n && ((cs && rd) || inta)) begin
      if (exp_q.size() == 0) begin
        check8("unexpected bus cycle", dout, 8'hxx);
      end else begin
        check8(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  task automatic wr_port(input logic port, input logic [7:0] v);
    @(posedge clk); #1;
    cs = 1'b1; wr = 1'b1; a0 = port; din = v;
    @(posedge clk); #1;
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_port(input logic port, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    cs = 1'b1; rd = 1'b1; a0 = port;
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic ack(input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    inta = 1'b1;
    @(posedge clk); #1;
    inta = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(posedge clk); #1;
    irq_in = v;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic check_int(input logic e, input string t);
    @(negedge clk);
    check8(t, {7'b0, int_out}, {7'b0, e});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    check_int(1'b0, "R1 int_out after reset");
    rd_port(1'b1, 8'hFF, "R1 mask after reset");
    rd_port(1'b0, 8'h00, "R1 request register after reset");
    set_irq(8'h10);
    rd_port(1'b0, 8'h10, "R10 request follows input");
    set_irq(8'h00);
    rd_port(1'b0, 8'h00, "R10 request drops with input");

    // full setup: base 0x20, cascade 0x04, mode word without auto EOI
    wr_port(1'b0, 8'h11);
    wr_port(1'b1, 8'h20);
    wr_port(1'b1, 8'h04);
    wr_port(1'b1, 8'h01);
    check8("R11 cascade word stored", casc_cfg, 8'h04);
    rd_port(1'b1, 8'hFF, "R2 setup words leave mask");

    wr_port(1'b1, 8'hF0);
    rd_port(1'b1, 8'hF0, "R3 mask readback");
    set_irq(8'h80);
    check_int(1'b0, "R3 masked input silent");
    set_irq(8'h0A);
    check_int(1'b1, "R4 unmasked request raises int");
    ack(8'h21, "R5 vector for input 1");
    wr_port(1'b0, 8'h0B);
    rd_port(1'b0, 8'h02, "R5 in-service bit set");
    check_int(1'b0, "R4 lower request blocked by service");
    rd_port(1'b0, 8'h02, "R8 selection persists");
    wr_port(1'b0, 8'h0A);
    rd_port(1'b0, 8'h0A, "R8 request register selected");
    wr_port(1'b0, 8'h0B);
    wr_port(1'b0, 8'h63);
    rd_port(1'b0, 8'h02, "R7 EOI of other bit keeps bit 1");
    wr_port(1'b0, 8'h61);
    rd_port(1'b0, 8'h00, "R7 EOI clears bit 1");
    check_int(1'b1, "R4 int returns after EOI");

    // nesting
    ack(8'h21, "R5 vector input 1 again");
    set_irq(8'h03);
    check_int(1'b1, "R4 higher request nests");
    ack(8'h20, "R5 vector for input 0");
    rd_port(1'b0, 8'h03, "R5 nested in-service");
    wr_port(1'b0, 8'h60);
    rd_port(1'b0, 8'h02, "R7 EOI clears bit 0 only");

    // spurious
    set_irq(8'h00);
    check_int(1'b0, "R4 no request no int");
    ack(8'h27, "R6 spurious vector");
    rd_port(1'b0, 8'h02, "R6 spurious keeps in-service");
    set_irq(8'h08);
    ack(8'h27, "R6 spurious when request outranked");
    rd_port(1'b0, 8'h02, "R6 in-service unchanged");

    // single-mode setup with auto EOI
    set_irq(8'h20);
    wr_port(1'b0, 8'h13);
    wr_port(1'b1, 8'h40);
    wr_port(1'b1, 8'h02);
    check8("R11 cascade word skipped", casc_cfg, 8'h04);
    rd_port(1'b1, 8'hFF, "R2 setup resets mask");
    rd_port(1'b0, 8'h20, "R2 setup selects request register");
    wr_port(1'b0, 8'h0B);
    rd_port(1'b0, 8'h00, "R2 setup clears in-service");
    wr_port(1'b1, 8'h00);
    rd_port(1'b1, 8'h00, "R3 mask load after sequence");
    check_int(1'b1, "R4 int with open mask");
    ack(8'h45, "R5 vector from new base");
    rd_port(1'b0, 8'h00, "R9 auto EOI leaves in-service");

    // setup without cascade and mode words
    wr_port(1'b0, 8'h12);
    wr_port(1'b1, 8'h80);
    wr_port(1'b1, 8'h55);
    rd_port(1'b1, 8'h55, "R11 sequence ends after base");
    check_int(1'b1, "R3 unmasked input 5");
    ack(8'h85, "R5 vector base 0x80 input 5");
    wr_port(1'b0, 8'h0B);
    rd_port(1'b0, 8'h20, "R9 no mode word sets in-service");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) check8("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule